// File: doc/BRIEF.md
# Row-Column 8x8 Transform Sequencer

This block drives a shared one-dimensional 8-point transform engine twice to build a two-dimensional 8x8 transform. Unsigned 8-bit pixels come in eight at a time, one row-vector per accepted handshake. Each pixel is re-centred around zero, and the vector is sent to the external engine.

The engine's row results are clamped to a signed 12-bit range. They are held in a transposition store that is written one row at a time. Once all eight rows are back, the block reads the store one column at a time and sends each column through the same engine.

The block then serialises the 64 second-pass coefficients onto a single output, with a valid flag and an end-of-block marker. The engine is modelled outside the block and is reached only through its request and response ports. Its responses come back in issue order.

Top module: `rcx_rowcol_2d`

## Requirements
- R1: After reset, pix_ready is 1, eng_req_valid is 0 and coef_valid is 0.
- R2: An input vector accepted on a rising edge (pix_valid and pix_ready both 1) appears on eng_req_vec in the following cycle, with eng_req_valid set. Lane i, at bits [12i+11:12i], holds the pixel from bits [8i+7:8i] minus 128, as 12-bit two's complement.
- R3: Exactly eight vectors are accepted per block. pix_ready stays 0 from the eighth acceptance until the cycle after the block's final coefficient is flagged, and pix_ready is 1 in that next cycle.
- R4: Each first-pass response lane is clamped to [-2048, 2047] before it is stored.
- R5: The column pass begins only after the eighth row response. For column c (0..7), in order, it issues one vector whose lane r is the clamped first-pass value of row r, lane c.
- R6: Consecutive column-pass requests are exactly 8 cycles apart.
- R7: Each block yields 64 coefficients on coef_data, one per cycle, with coef_valid set. Word 8c+k is lane k (bits [18k+17:18k]) of the response to column request c, passed on at full 18-bit signed width.
- R8: coef_last is 1 on the 64th coefficient of a block and 0 on every other cycle.
- R9: Blocks offered back to back are each processed with no data carried from the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input row-vector present |
| pix_vec | input | 64 | Eight unsigned pixels, lane i in bits [8i+7:8i] |
| pix_ready | output | 1 | Block can take an input vector |
| eng_req_valid | output | 1 | Request to the 1-D engine |
| eng_req_vec | output | 96 | Eight signed 12-bit engine inputs |
| eng_rsp_valid | input | 1 | Engine result present |
| eng_rsp_vec | input | 144 | Eight signed 18-bit engine results |
| coef_valid | output | 1 | Output coefficient valid |
| coef_data | output | 18 | Signed output coefficient |
| coef_last | output | 1 | Final coefficient of the block |

## Verification
The embedded assertions check several properties on every cycle:
- every accepted vector is followed by an engine request;
- no input is accepted while coefficients are streaming;
- column requests are never adjacent;
- the engine never answers more requests than were issued;
- the transposition store is never written and read in the same cycle;
- the serialiser is never reloaded mid-vector.

Only the bench's scenarios can show that the numbers are right: the level shift, the clamping, the row-to-column transposition and the output ordering. The bench drives blocks that sweep all 256 pixel values, constant extremes that force clamping, and irregular patterns, and compares them against transforms it computes itself.

// File: rtl/rcx_pkg.sv
package rcx_pkg;
  localparam int unsigned DEF_N     = 8;
  localparam int unsigned DEF_PIX_W = 8;
  localparam int unsigned DEF_MID_W = 12;
  localparam int unsigned DEF_RSP_W = 18;

  typedef enum logic {PH_ROW = 1'b0, PH_COL = 1'b1} phase_t;
endpackage

// File: rtl/rcx_lvl_shift.sv
module rcx_lvl_shift #(
  parameter int unsigned N     = rcx_pkg::DEF_N,
  parameter int unsigned PIX_W = rcx_pkg::DEF_PIX_W,
  parameter int unsigned MID_W = rcx_pkg::DEF_MID_W
) (
  input  logic [N*PIX_W-1:0] pix_in,
  output logic [N*MID_W-1:0] sgn_out
);
  localparam int unsigned EXT = MID_W - PIX_W;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [PIX_W-1:0] p;
    assign p = pix_in[g*PIX_W +: PIX_W];
    // Subtracting mid-scale is an MSB flip followed by sign extension.
    assign sgn_out[g*MID_W +: MID_W] = {{EXT{~p[PIX_W-1]}}, ~p[PIX_W-1], p[PIX_W-2:0]};
  end
endmodule

// File: rtl/rcx_sat_lanes.sv
module rcx_sat_lanes #(
  parameter int unsigned N     = rcx_pkg::DEF_N,
  parameter int unsigned IN_W  = rcx_pkg::DEF_RSP_W,
  parameter int unsigned OUT_W = rcx_pkg::DEF_MID_W
) (
  input  logic [N*IN_W-1:0]  wide_in,
  output logic [N*OUT_W-1:0] nar_out
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic signed [IN_W-1:0] w;
    assign w = $signed(wide_in[g*IN_W +: IN_W]);
    always_comb begin
      if (w > HI)      nar_out[g*OUT_W +: OUT_W] = HI[OUT_W-1:0];
      else if (w < LO) nar_out[g*OUT_W +: OUT_W] = LO[OUT_W-1:0];
      else             nar_out[g*OUT_W +: OUT_W] = w[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/rcx_tstore.sv
module rcx_tstore #(
  parameter int unsigned N = rcx_pkg::DEF_N,
  parameter int unsigned W = rcx_pkg::DEF_MID_W,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [N*W-1:0] wvec,
  input  logic           re,
  input  logic [AW-1:0]  raddr,
  input  logic [AW-1:0]  rcol,
  output logic [W-1:0]   rdata
);
  logic [W-1:0]  bank_q [N];
  logic [AW-1:0] sel_d;

  // One bank per output lane; a row write hits every bank at the same address.
  for (genvar g = 0; g < N; g++) begin : g_bank
    logic [W-1:0] mem [N];
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wvec[g*W +: W];
      if (re) q <= mem[raddr];
    end
    assign bank_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)     sel_d <= '0;
    else if (re) sel_d <= rcol;
  end

  assign rdata = bank_q[sel_d];

  p_no_rw_clash_r5: assert property (@(posedge clk) disable iff (rst) !(we && re))
    else $error("transposition store written and read together");
endmodule

// File: rtl/rcx_serializer.sv
module rcx_serializer #(
  parameter int unsigned N = rcx_pkg::DEF_N,
  parameter int unsigned W = rcx_pkg::DEF_RSP_W,
  localparam int unsigned AW  = $clog2(N),
  localparam int unsigned TOT = N * N,
  localparam int unsigned TW  = $clog2(TOT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N*W-1:0] vec,
  output logic           valid,
  output logic [W-1:0]   data,
  output logic           last
);
  logic [W-1:0]  sreg [N];
  logic [AW-1:0] idx;
  logic          busy;
  logic [TW-1:0] tot;

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < N; i++) sreg[i] <= vec[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      last  <= 1'b0;
      data  <= '0;
      busy  <= 1'b0;
      idx   <= '0;
      tot   <= '0;
    end else begin
      valid <= 1'b0;
      last  <= 1'b0;
      if (load) begin
        data  <= vec[W-1:0];
        valid <= 1'b1;
        last  <= (tot == TW'(TOT - 1));
        tot   <= tot + 1'b1;
        idx   <= AW'(1);
        busy  <= 1'b1;
      end else if (busy) begin
        data  <= sreg[idx];
        valid <= 1'b1;
        last  <= (tot == TW'(TOT - 1));
        tot   <= tot + 1'b1;
        idx   <= idx + 1'b1;
        if (idx == AW'(N - 1)) busy <= 1'b0;
      end
    end
  end

  p_load_when_idle_r7: assert property (@(posedge clk) disable iff (rst) load |-> !busy)
    else $error("serialiser reloaded while draining");
  p_last_has_valid_r8: assert property (@(posedge clk) disable iff (rst) last |-> valid)
    else $error("last flag without valid");
endmodule

// File: rtl/rcx_rowcol_2d.sv
module rcx_rowcol_2d #(
  parameter int unsigned N     = rcx_pkg::DEF_N,
  parameter int unsigned PIX_W = rcx_pkg::DEF_PIX_W,
  parameter int unsigned MID_W = rcx_pkg::DEF_MID_W,
  parameter int unsigned RSP_W = rcx_pkg::DEF_RSP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic [N*PIX_W-1:0]   pix_vec,
  output logic                 pix_ready,
  output logic                 eng_req_valid,
  output logic [N*MID_W-1:0]   eng_req_vec,
  input  logic                 eng_rsp_valid,
  input  logic [N*RSP_W-1:0]   eng_rsp_vec,
  output logic                 coef_valid,
  output logic [RSP_W-1:0]     coef_data,
  output logic                 coef_last
);
  import rcx_pkg::*;

  localparam int unsigned AW  = $clog2(N);
  localparam int unsigned CW  = AW + 1;
  localparam int unsigned RCW = $clog2(N * N);
  localparam int unsigned OW  = 5;

  phase_t            phase;
  logic [CW-1:0]     in_cnt;
  logic [AW-1:0]     rrsp_cnt;
  logic [RCW-1:0]    rd_cnt;
  logic              rd_act;
  logic              rd_v_d;
  logic [AW-1:0]     rd_row_d;
  logic [MID_W-1:0]  col_buf [N];
  logic [MID_W-1:0]  rd_word;
  logic [N*MID_W-1:0] shifted;
  logic [N*MID_W-1:0] row_sat;
  logic [N*MID_W-1:0] col_vec_nxt;
  logic              accept;
  logic              row_wr;
  logic              col_load;
  logic [OW-1:0]     outstanding;

  assign pix_ready = (phase == PH_ROW) && (in_cnt != CW'(N));
  assign accept    = pix_valid && pix_ready;
  assign row_wr    = (phase == PH_ROW) && eng_rsp_valid;
  assign col_load  = (phase == PH_COL) && eng_rsp_valid;

  rcx_lvl_shift #(.N(N), .PIX_W(PIX_W), .MID_W(MID_W)) u_shift (
    .pix_in (pix_vec),
    .sgn_out(shifted)
  );

  rcx_sat_lanes #(.N(N), .IN_W(RSP_W), .OUT_W(MID_W)) u_sat (
    .wide_in(eng_rsp_vec),
    .nar_out(row_sat)
  );

  rcx_tstore #(.N(N), .W(MID_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (row_wr),
    .waddr(rrsp_cnt),
    .wvec (row_sat),
    .re   (rd_act),
    .raddr(rd_cnt[AW-1:0]),
    .rcol (rd_cnt[RCW-1:AW]),
    .rdata(rd_word)
  );

  rcx_serializer #(.N(N), .W(RSP_W)) u_ser (
    .clk  (clk),
    .rst  (rst),
    .load (col_load),
    .vec  (eng_rsp_vec),
    .valid(coef_valid),
    .data (coef_data),
    .last (coef_last)
  );

  // Column vector: earlier rows from the gather buffer, last row straight from the store.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (i == N - 1) col_vec_nxt[i*MID_W +: MID_W] = rd_word;
      else            col_vec_nxt[i*MID_W +: MID_W] = col_buf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_v_d) col_buf[rd_row_d] <= rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_ROW;
      in_cnt        <= '0;
      rrsp_cnt      <= '0;
      rd_cnt        <= '0;
      rd_act        <= 1'b0;
      rd_v_d        <= 1'b0;
      rd_row_d      <= '0;
      eng_req_valid <= 1'b0;
      eng_req_vec   <= '0;
    end else begin
      eng_req_valid <= 1'b0;
      rd_v_d        <= rd_act;
      rd_row_d      <= rd_cnt[AW-1:0];

      if (accept) begin
        in_cnt        <= in_cnt + 1'b1;
        eng_req_valid <= 1'b1;
        eng_req_vec   <= shifted;
      end

      if (row_wr) begin
        rrsp_cnt <= rrsp_cnt + 1'b1;
        if (rrsp_cnt == AW'(N - 1)) begin
          phase  <= PH_COL;
          rd_act <= 1'b1;
          rd_cnt <= '0;
        end
      end

      if (rd_act) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_cnt == RCW'(N * N - 1)) rd_act <= 1'b0;
      end

      if (rd_v_d && (rd_row_d == AW'(N - 1))) begin
        eng_req_valid <= 1'b1;
        eng_req_vec   <= col_vec_nxt;
      end

      if (coef_last) begin
        phase  <= PH_ROW;
        in_cnt <= '0;
      end
    end
  end

  // Engine occupancy, used only to check that responses match requests.
  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else     outstanding <= outstanding + OW'(eng_req_valid) - OW'(eng_rsp_valid);
  end

  p_accept_issues_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> eng_req_valid)
    else $error("accepted vector not issued");
  p_no_input_while_emit_r3: assert property (@(posedge clk) disable iff (rst)
    coef_valid |-> !pix_ready)
    else $error("input open while coefficients stream");
  p_col_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_req_valid && phase == PH_COL) |=> !eng_req_valid)
    else $error("back-to-back column requests");
  p_rsp_matches_req_r9: assert property (@(posedge clk) disable iff (rst)
    eng_rsp_valid |-> (outstanding != '0))
    else $error("engine response without request");
endmodule

// File: tb/tb_rcx_rowcol_2d.sv
module tb_rcx_rowcol_2d;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int PW    = 8;
  localparam int MW    = 12;
  localparam int RW    = 18;
  localparam int LAT   = 9;
  localparam int NBLK  = 9;

  logic            clk = 1'b0;
  logic            rst;
  logic            pix_valid;
  logic [N*PW-1:0] pix_vec;
  logic            pix_ready;
  logic            eng_req_valid;
  logic [N*MW-1:0] eng_req_vec;
  logic            eng_rsp_valid;
  logic [N*RW-1:0] eng_rsp_vec;
  logic            coef_valid;
  logic [RW-1:0]   coef_data;
  logic            coef_last;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int xs [NBLK][N][N];
  int tm [NBLK][N][N];
  int ym [NBLK][N][N];

  always #(CLK_P/2) clk = ~clk;

  rcx_rowcol_2d dut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_vec(pix_vec), .pix_ready(pix_ready),
    .eng_req_valid(eng_req_valid), .eng_req_vec(eng_req_vec),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_vec(eng_rsp_vec),
    .coef_valid(coef_valid), .coef_data(coef_data), .coef_last(coef_last)
  );

  function automatic int mval(int k, int n);
    return ((3*k + 5*n) % 7) - 1;
  endfunction

  function automatic int clamp12(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int pixf(int b, int r, int i);
    case (b)
      0: return 128;
      1: return 255;
      2: return 0;
      3, 4, 5, 6: return (b - 3) * 64 + r * 8 + i;
      7: return (r * 73 + i * 151 + 17) % 256;
      default: return ((r + i) % 2 == 1) ? 255 : 0;
    endcase
  endfunction

  // External 1-D engine model: fixed integer matrix, 9-cycle pipeline.
  logic            pv [LAT];
  logic [N*RW-1:0] pd [LAT];
  logic [N*RW-1:0] eng_calc;
  always_comb begin
    for (int k = 0; k < N; k++) begin
      int acc;
      acc = 0;
      for (int n = 0; n < N; n++) acc += mval(k, n) * int'($signed(eng_req_vec[n*MW +: MW]));
      eng_calc[k*RW +: RW] = RW'(acc);
    end
  end
  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < LAT; s++) pv[s] <= 1'b0;
    end else begin
      pv[0] <= eng_req_valid;
      pd[0] <= eng_calc;
      for (int s = 1; s < LAT; s++) begin
        pv[s] <= pv[s-1];
        pd[s] <= pd[s-1];
      end
    end
  end
  assign eng_rsp_valid = pv[LAT-1];
  assign eng_rsp_vec   = pd[LAT-1];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor, sampled on falling edges.
  int req_cnt = 0, out_cnt = 0, cyc = 0, last_col_cyc = 0;
  int acc_in = 0, viol = 0;
  bit stalled = 0, want_ready = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (want_ready) begin
        chk(pix_ready == 1'b1, "R3 ready after last", int'(pix_ready), 1);
        want_ready = 0;
      end
      if (stalled && pix_ready) viol++;
      if (pix_valid && pix_ready) begin
        acc_in++;
        if (acc_in % N == 0) stalled = 1;
      end
      if (eng_req_valid) begin
        int idx, blk, bad, fa, fe;
        idx = req_cnt % 16; blk = req_cnt / 16; bad = 0; fa = 0; fe = 0;
        if (blk < NBLK) begin
          for (int i = 0; i < N; i++) begin
            int a, e;
            a = int'($signed(eng_req_vec[i*MW +: MW]));
            e = (idx < 8) ? xs[blk][idx][i] : tm[blk][i][idx-8];
            if (a != e && !bad) begin bad = 1; fa = a; fe = e; end
          end
          if (idx < 8) chk(!bad, "R2 row request lane", fa, fe);
          else begin
            chk(!bad, "R4/R5 column request lane", fa, fe);
            if (idx > 8) chk(cyc - last_col_cyc == 8, "R6 column spacing", cyc - last_col_cyc, 8);
            last_col_cyc = cyc;
          end
        end
        req_cnt++;
      end
      if (coef_valid) begin
        int o, blk, e, a;
        o = out_cnt % 64; blk = out_cnt / 64;
        if (blk < NBLK) begin
          e = ym[blk][o/8][o%8];
          a = int'($signed(coef_data));
          chk(a == e, "R7/R9 coefficient", a, e);
          chk(coef_last == (o == 63), "R8 last flag", int'(coef_last), int'(o == 63));
        end
        out_cnt++;
      end else if (coef_last) begin
        chk(0, "R8 last without valid", 1, 0);
      end
      if (coef_last) begin
        chk(viol == 0, "R3 stall held", viol, 0);
        viol = 0; stalled = 0; want_ready = 1;
      end
    end
  end

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      for (int r = 0; r < N; r++)
        for (int i = 0; i < N; i++) xs[b][r][i] = pixf(b, r, i) - 128;
      for (int r = 0; r < N; r++)
        for (int k = 0; k < N; k++) begin
          int s; s = 0;
          for (int n = 0; n < N; n++) s += mval(k, n) * xs[b][r][n];
          tm[b][r][k] = clamp12(s);
        end
      for (int c = 0; c < N; c++)
        for (int k = 0; k < N; k++) begin
          int s; s = 0;
          for (int r = 0; r < N; r++) s += mval(k, r) * tm[b][r][c];
          ym[b][c][k] = s;
        end
    end

    rst = 1'b1; pix_valid = 1'b0; pix_vec = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(pix_ready == 1'b1, "R1 ready after reset", int'(pix_ready), 1);
    chk(eng_req_valid == 1'b0, "R1 no request after reset", int'(eng_req_valid), 0);
    chk(coef_valid == 1'b0, "R1 no output after reset", int'(coef_valid), 0);

    for (int b = 0; b < NBLK; b++) begin
      for (int r = 0; r < N; r++) begin
        for (int i = 0; i < N; i++) pix_vec[i*PW +: PW] = PW'(pixf(b, r, i));
        pix_valid = 1'b1;
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
      end
      pix_valid = 1'b0;
    end

    while (out_cnt < NBLK * 64) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(req_cnt == NBLK * 16, "R5 request count", req_cnt, NBLK * 16);
    chk(out_cnt == NBLK * 64, "R7 output count", out_cnt, NBLK * 64);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", out_cnt, NBLK * 64);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule